// File: doc/BRIEF.md
# Microcoded Field-Arithmetic Sequencer

This block is the control and storage core of a finite-field accelerator. It contains a dual-port register file of 256 wide words, a program counter and the per-cycle decode of an externally held instruction ROM. Each instruction word directly drives several things in the cycle it is presented: both RAM ports, an add/subtract unit with its operand muxes, the issue of one of several replicated multipliers, and the choice of which multiplier result is written back. The multipliers and the adder are fixed-latency behavioural stand-ins with the same timing as the real units. Instruction scheduling is done offline and is not part of this block.

A host fills registers and reads them back over a 64-bit port, one 64-bit slice at a time, with the slice index selecting the word. A start pulse launches the program at address 0. A busy output stays high until a halt instruction is reached, and host accesses are refused while busy is high. An instruction that writes back a multiplier result before that result is ready sets a sticky error flag, and the write does not happen.

Top module: `fas_seq_core`

## Requirements
- R1: A host write (host_we) while busy is low stores host_wdata into the 64-bit slice host_idx of register host_addr. Slice 0 is bits 63:0 and higher indices are more significant.
- R2: A host read (host_re) while busy is low presents that slice on host_rdata two clock cycles later. host_rdata then holds until the next accepted read.
- R3: After reset, busy, err, pc and host_rdata are 0. A start pulse sets busy, sets pc to 0 and clears err on the next cycle. While busy, one instruction executes per cycle and pc then increments by one.
- R4: An instruction with bit 0 (halt) set clears busy on the next cycle, executes nothing else, and leaves pc unchanged.
- R5: Port A is controlled by bits 2:1 (op) and 10:3 (address), and port B by bits 12:11 and 20:13. The op codes are 0 idle, 1 read and 2 write. A read issued at cycle k is the operand seen by the instruction at cycle k+2. Both ports may read in the same cycle.
- R6: When bit 21 is set, the add/sub unit loads a new result, visible to the next instruction. Bit 22 selects subtract. Bit 23 selects the first operand: 0 is the port A data and 1 is the previous adder result. Bits 25:24 select the second operand: 0 is the port B data, 1 is 2p and 2 is zero. Arithmetic is modulo 2^W. A port A write stores the adder result.
- R7: When bit 26 is set, the multiplier chosen by bits 28:27 starts on the current port A and port B data. Its low-W-bit product becomes valid for the instruction MUL_LAT+1 cycles after issue. A port B write stores the result of the unit chosen by bits 30:29.
- R8: A port B write from a unit whose result is not valid sets the sticky err flag and leaves the register unchanged.
- R9: Host writes and reads issued while busy is high are ignored: no register changes and host_rdata holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch the program at address 0 |
| pc | output | 8 | Instruction ROM address |
| instr | input | 31 | Instruction word at pc |
| busy | output | 1 | Program running |
| err | output | 1 | Sticky early-writeback error |
| host_we | input | 1 | Host slice write |
| host_re | input | 1 | Host slice read |
| host_addr | input | 8 | Host register address |
| host_idx | input | 2 | Host 64-bit slice index |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data |

## Verification
A first program uses both ports reading in one cycle and chains adds, subtracts against 2p and a zero operand. It also issues two multipliers back to back and writes each one back at the first legal cycle. This program separates errors in read latency, operand selection, adder chaining and result-select routing. A second program writes back a multiplier result one cycle after issue while the host tries writes and reads, which exposes a missing error flag, a write that is not suppressed, and host accesses that are not blocked. A halt-only run then shows that start clears the error and that halt drops busy one cycle later. A behavioural model compares pc, busy, err and host_rdata on every clock.

// File: rtl/fas_pkg.sv
package fas_pkg;
  typedef enum logic [1:0] {
    PORT_IDLE  = 2'd0,
    PORT_READ  = 2'd1,
    PORT_WRITE = 2'd2
  } port_op_e;

  typedef enum logic [1:0] {
    OP2_RAMB = 2'd0,
    OP2_TWOP = 2'd1,
    OP2_ZERO = 2'd2
  } op2_sel_e;
endpackage

// File: rtl/fas_regfile.sv
module fas_regfile import fas_pkg::*; #(
  parameter int W  = 256,
  parameter int AW = 8,
  parameter int HW = 64,
  localparam int IDXW = $clog2(W / HW)
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  port_op_e        a_op,
  input  logic [AW-1:0]   a_addr,
  input  logic [W-1:0]    a_wdata,
  input  port_op_e        b_op,
  input  logic [AW-1:0]   b_addr,
  input  logic [W-1:0]    b_wdata,
  input  logic            h_we,
  input  logic            h_re,
  input  logic [AW-1:0]   h_addr,
  input  logic [IDXW-1:0] h_idx,
  input  logic [HW-1:0]   h_wdata,
  output logic [W-1:0]    a_rdata,
  output logic [W-1:0]    b_rdata,
  output logic [HW-1:0]   h_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [W-1:0]  a_s1, a_s1_n, a_s2, b_s1, b_s1_n, b_s2;
  logic [HW-1:0] h_s1, h_s1_n, h_s2;

  // storage array: no reset, writes commit at the clock edge
  always_ff @(posedge clk) begin
    if (a_op == PORT_WRITE) mem[a_addr] <= a_wdata;
    if (b_op == PORT_WRITE) mem[b_addr] <= b_wdata;
    if (h_we) mem[h_addr][h_idx*HW +: HW] <= h_wdata;
  end

  // first read stage loads only on a read, otherwise holds
  always_comb begin
    a_s1_n = a_s1;
    b_s1_n = b_s1;
    h_s1_n = h_s1;
    if (a_op == PORT_READ) a_s1_n = mem[a_addr];
    if (b_op == PORT_READ) b_s1_n = mem[b_addr];
    if (h_re) h_s1_n = mem[h_addr][h_idx*HW +: HW];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      a_s1 <= '0; a_s2 <= '0;
      b_s1 <= '0; b_s2 <= '0;
      h_s1 <= '0; h_s2 <= '0;
    end else begin
      a_s1 <= a_s1_n; a_s2 <= a_s1;
      b_s1 <= b_s1_n; b_s2 <= b_s1;
      h_s1 <= h_s1_n; h_s2 <= h_s1;
    end
  end

  assign a_rdata = a_s2;
  assign b_rdata = b_s2;
  assign h_rdata = h_s2;

  // two idle cycles on the host side leave host data unchanged
  assert_hrd_hold_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    !h_re ##1 !h_re |=> $stable(h_rdata));
endmodule

// File: rtl/fas_addsub.sv
module fas_addsub import fas_pkg::*; #(
  parameter int W = 256,
  parameter logic [W-1:0] TWO_P = '0
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         go,
  input  logic         sub,
  input  logic         op1_fb,
  input  op2_sel_e     op2_sel,
  input  logic [W-1:0] ram_a,
  input  logic [W-1:0] ram_b,
  output logic [W-1:0] res
);
  logic [W-1:0] op1, op2, res_n;

  always_comb begin
    op1 = op1_fb ? res : ram_a;
    case (op2_sel)
      OP2_RAMB: op2 = ram_b;
      OP2_TWOP: op2 = TWO_P;
      default:  op2 = '0;
    endcase
    res_n = res;
    if (go) res_n = sub ? (op1 - op2) : (op1 + op2);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) res <= '0;
    else         res <= res_n;
  end

  assert_add_hold_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    !go |=> $stable(res));
endmodule

// File: rtl/fas_mulstub.sv
module fas_mulstub #(
  parameter int W   = 256,
  parameter int LAT = 4,
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         issue,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         valid
);
  logic [CW-1:0] cnt, cnt_n;
  logic [W-1:0]  res_n;
  logic          valid_n;

  always_comb begin
    cnt_n   = cnt;
    res_n   = res;
    valid_n = valid;
    if (issue) begin
      cnt_n   = CW'(LAT);
      res_n   = a * b;
      valid_n = 1'b0;
    end else if (cnt != '0) begin
      cnt_n = cnt - CW'(1);
      if (cnt == CW'(1)) valid_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt <= '0; res <= '0; valid <= 1'b0;
    end else begin
      cnt <= cnt_n; res <= res_n; valid <= valid_n;
    end
  end

  assert_issue_invalid_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    issue |=> !valid);
  assert_valid_stable_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    valid && !issue |=> valid && $stable(res));
endmodule

// File: rtl/fas_seq_core.sv
module fas_seq_core import fas_pkg::*; #(
  parameter int W       = 256,
  parameter int AW      = 8,
  parameter int PCW     = 8,
  parameter int NMUL    = 4,
  parameter int MUL_LAT = 4,
  parameter int HW      = 64,
  parameter logic [W-1:0] MODULUS = {2'b00, {(W-2){1'b1}}},
  localparam int UW   = $clog2(NMUL),
  localparam int IDXW = $clog2(W / HW),
  localparam int IW   = 11 + 2*AW + 2*UW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic [PCW-1:0]  pc,
  input  logic [IW-1:0]   instr,
  output logic            busy,
  output logic            err,
  input  logic            host_we,
  input  logic            host_re,
  input  logic [AW-1:0]   host_addr,
  input  logic [IDXW-1:0] host_idx,
  input  logic [HW-1:0]   host_wdata,
  output logic [HW-1:0]   host_rdata
);
  localparam int F_HALT = 0;
  localparam int F_AOP  = 1;
  localparam int F_AADR = 3;
  localparam int F_BOP  = 3 + AW;
  localparam int F_BADR = 5 + AW;
  localparam int F_ADD  = 5 + 2*AW;
  localparam int F_SUB  = 6 + 2*AW;
  localparam int F_OP1  = 7 + 2*AW;
  localparam int F_OP2  = 8 + 2*AW;
  localparam int F_MGO  = 10 + 2*AW;
  localparam int F_MU   = 11 + 2*AW;
  localparam int F_RS   = 11 + 2*AW + UW;
  localparam logic [W-1:0] TWO_P = MODULUS << 1;

  // reset: asserted asynchronously, released through two flops
  logic rst_m, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rst_m <= 1'b0; rst_ni <= 1'b0; end
    else        begin rst_m <= 1'b1; rst_ni <= rst_m; end
  end

  logic [PCW-1:0] pc_n;
  logic           busy_n, err_n, ex, halt, b_bad;
  port_op_e       a_op, b_op, b_raw;
  logic [UW-1:0]  rs;
  logic [W-1:0]   ram_a, ram_b, add_res;
  logic [W-1:0]   mul_res [NMUL];
  logic [NMUL-1:0] mul_valid;

  assign halt = instr[F_HALT];
  assign ex   = busy & ~start & ~halt;
  assign rs   = instr[F_RS +: UW];

  always_comb begin
    a_op  = ex ? port_op_e'(instr[F_AOP +: 2]) : PORT_IDLE;
    b_raw = ex ? port_op_e'(instr[F_BOP +: 2]) : PORT_IDLE;
    b_bad = (b_raw == PORT_WRITE) && !mul_valid[rs];
    b_op  = b_bad ? PORT_IDLE : b_raw;
    pc_n   = pc;
    busy_n = busy;
    err_n  = err;
    if (start) begin
      pc_n = '0; busy_n = 1'b1; err_n = 1'b0;
    end else if (busy) begin
      if (halt) busy_n = 1'b0;
      else      pc_n   = pc + PCW'(1);
      if (b_bad) err_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pc <= '0; busy <= 1'b0; err <= 1'b0;
    end else begin
      pc <= pc_n; busy <= busy_n; err <= err_n;
    end
  end

  fas_regfile #(.W(W), .AW(AW), .HW(HW)) u_rf (
    .clk(clk), .rst_ni(rst_ni),
    .a_op(a_op), .a_addr(instr[F_AADR +: AW]), .a_wdata(add_res),
    .b_op(b_op), .b_addr(instr[F_BADR +: AW]), .b_wdata(mul_res[rs]),
    .h_we(host_we & ~busy), .h_re(host_re & ~busy),
    .h_addr(host_addr), .h_idx(host_idx), .h_wdata(host_wdata),
    .a_rdata(ram_a), .b_rdata(ram_b), .h_rdata(host_rdata)
  );

  fas_addsub #(.W(W), .TWO_P(TWO_P)) u_add (
    .clk(clk), .rst_ni(rst_ni),
    .go(ex & instr[F_ADD]), .sub(instr[F_SUB]), .op1_fb(instr[F_OP1]),
    .op2_sel(op2_sel_e'(instr[F_OP2 +: 2])),
    .ram_a(ram_a), .ram_b(ram_b), .res(add_res)
  );

  for (genvar g = 0; g < NMUL; g++) begin : g_mul
    fas_mulstub #(.W(W), .LAT(MUL_LAT)) u_mul (
      .clk(clk), .rst_ni(rst_ni),
      .issue(ex & instr[F_MGO] & (instr[F_MU +: UW] == UW'(g))),
      .a(ram_a), .b(ram_b), .res(mul_res[g]), .valid(mul_valid[g])
    );
  end

  assert_start_pc0_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    start |=> busy && (pc == '0) && !err);
  assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    busy && !start && !halt |=> pc == $past(pc) + PCW'(1));
  assert_halt_idle_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    busy && !start && halt |=> !busy && $stable(pc));
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    err && !start |=> err);
  assert_idle_no_err_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy && !err && !start |=> !err);
endmodule

// File: tb/sim_fas_seq_core.sv
module sim_fas_seq_core;
  localparam int W = 256;
  localparam int LAT = 4;
  localparam logic [W-1:0] TWOP = (W'(1) << (W-1)) - W'(2);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, busy, err, host_we, host_re;
  logic [7:0] pc, host_addr;
  logic [1:0] host_idx;
  logic [63:0] host_wdata, host_rdata;
  logic [30:0] instr;
  logic [30:0] rom [256];
  assign instr = rom[pc];

  fas_seq_core u0 (.clk(clk), .rst_n(rst_n), .start(start), .pc(pc), .instr(instr),
    .busy(busy), .err(err), .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
    .host_idx(host_idx), .host_wdata(host_wdata), .host_rdata(host_rdata));

  int checks = 0, errors = 0;
  bit cmp_en = 0;

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [30:0] mk(int aop, int aad, int bop, int bad, int addgo, int sub,
                                     int op1, int op2, int mgo, int mu, int rs, int hlt);
    logic [30:0] v = '0;
    v[0] = hlt[0]; v[2:1] = aop[1:0]; v[10:3] = aad[7:0]; v[12:11] = bop[1:0];
    v[20:13] = bad[7:0]; v[21] = addgo[0]; v[22] = sub[0]; v[23] = op1[0];
    v[25:24] = op2[1:0]; v[26] = mgo[0]; v[28:27] = mu[1:0]; v[30:29] = rs[1:0];
    return v;
  endfunction

  // behavioural reference, advanced on every rising edge
  logic [W-1:0] m_mem [256];
  logic [W-1:0] m_a1, m_a2, m_b1, m_b2, m_add;
  logic [W-1:0] m_mres [4];
  int m_cnt [4];
  bit m_val [4];
  logic [63:0] m_h1, m_h2;
  int m_pc;
  bit m_busy, m_err;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_a1 = '0; m_a2 = '0; m_b1 = '0; m_b2 = '0; m_add = '0; m_h1 = '0; m_h2 = '0;
      m_pc = 0; m_busy = 0; m_err = 0;
      for (int u = 0; u < 4; u++) begin m_mres[u] = '0; m_cnt[u] = 0; m_val[u] = 0; end
    end else begin
      logic [30:0] i;
      logic [W-1:0] o1, o2, na1, nb1, oa2, ob2, oadd;
      logic [W-1:0] ores [4];
      bit oval [4];
      bit exe;
      i = rom[m_pc[7:0]];
      exe = m_busy && !start && !i[0];
      oa2 = m_a2; ob2 = m_b2; oadd = m_add;
      for (int u = 0; u < 4; u++) begin ores[u] = m_mres[u]; oval[u] = m_val[u]; end
      na1 = (exe && i[2:1] == 2'd1) ? m_mem[i[10:3]] : m_a1;
      nb1 = (exe && i[12:11] == 2'd1) ? m_mem[i[20:13]] : m_b1;
      m_h2 = m_h1;
      if (!m_busy && host_re) m_h1 = m_mem[host_addr][host_idx*64 +: 64];
      if (exe && i[2:1] == 2'd2) m_mem[i[10:3]] = oadd;
      if (exe && i[12:11] == 2'd2) begin
        if (oval[i[30:29]]) m_mem[i[20:13]] = ores[i[30:29]];
        else m_err = 1;
      end
      if (!m_busy && host_we) m_mem[host_addr][host_idx*64 +: 64] = host_wdata;
      if (exe && i[21]) begin
        o1 = i[23] ? oadd : oa2;
        o2 = (i[25:24] == 2'd0) ? ob2 : (i[25:24] == 2'd1) ? TWOP : '0;
        m_add = i[22] ? o1 - o2 : o1 + o2;
      end
      for (int u = 0; u < 4; u++) begin
        if (exe && i[26] && i[28:27] == u[1:0]) begin
          m_mres[u] = oa2 * ob2; m_cnt[u] = LAT; m_val[u] = 0;
        end else if (m_cnt[u] > 0) begin
          if (m_cnt[u] == 1) m_val[u] = 1;
          m_cnt[u]--;
        end
      end
      m_a2 = m_a1; m_a1 = na1; m_b2 = m_b1; m_b1 = nb1;
      if (start) begin m_busy = 1; m_pc = 0; m_err = 0; end
      else if (m_busy) begin
        if (i[0]) m_busy = 0;
        else m_pc = (m_pc + 1) % 256;
      end
    end
  end

  always @(negedge clk) if (cmp_en) begin
    chk("R3 model busy", W'(busy), W'(m_busy));
    chk("R3 model pc", W'(pc), W'(m_pc));
    chk("R8 model err", W'(err), W'(m_err));
    chk("R2 model host_rdata", W'(host_rdata), W'(m_h2));
  end

  task automatic hwrite(int a, logic [W-1:0] v);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      host_we = 1; host_addr = a[7:0]; host_idx = k[1:0]; host_wdata = v[k*64 +: 64];
    end
    @(negedge clk); host_we = 0;
  endtask

  task automatic hchk(string tag, int a, logic [W-1:0] exp);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); host_re = 1; host_addr = a[7:0]; host_idx = k[1:0];
      @(negedge clk); host_re = 0;
      @(negedge clk); chk(tag, W'(host_rdata), W'(exp[k*64 +: 64]));
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 60 && busy; n++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  logic [W-1:0] va, vb, vc;

  initial begin
    rst_n = 0; start = 0; host_we = 0; host_re = 0; host_addr = '0; host_idx = '0; host_wdata = '0;
    for (int k = 0; k < 256; k++) rom[k] = mk(0,0,0,0,0,0,0,0,0,0,0,1);
    va = {64'hF123_4567_89AB_CDEF, 64'h0011_2233_4455_6677, 64'h8899_AABB_CCDD_EEFF, 64'h0F0E_0D0C_0B0A_0908};
    vb = {64'hC000_0000_0000_0001, 64'h1357_9BDF_0246_8ACE, 64'hFFFF_0000_FFFF_0000, 64'h1234_5678_9ABC_DEF0};
    vc = {64'hDEAD_BEEF_0000_0001, 64'h0000_0002_CAFE_F00D, 64'h5555_AAAA_5555_AAAA, 64'h7777_6666_5555_4444};
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R3 reset state
    chk("R3 reset busy", W'(busy), '0);
    chk("R3 reset err", W'(err), '0);
    chk("R3 reset pc", W'(pc), '0);
    chk("R3 reset host_rdata", W'(host_rdata), '0);
    cmp_en = 1;

    // R1 / R2: slice load and readback
    hwrite(0, va); hwrite(1, vb); hwrite(15, vc);
    hchk("R1 load r0", 0, va);
    hchk("R1 load r1", 1, vb);
    hchk("R2 read r15", 15, vc);

    // program 1: dual read, add chain, two multipliers
    rom[0] = mk(1,0,1,1, 0,0,0,0, 0,0,0,0);
    rom[1] = mk(0,0,0,0, 0,0,0,0, 0,0,0,0);
    rom[2] = mk(0,0,0,0, 1,0,0,0, 1,0,0,0);
    rom[3] = mk(2,10,0,0, 1,1,1,1, 1,1,0,0);
    rom[4] = mk(2,11,0,0, 1,0,0,2, 0,0,0,0);
    rom[5] = mk(2,12,0,0, 0,0,0,0, 0,0,0,0);
    rom[6] = mk(0,0,0,0, 0,0,0,0, 0,0,0,0);
    rom[7] = mk(0,0,2,13, 0,0,0,0, 0,0,0,0);
    rom[8] = mk(0,0,2,14, 0,0,0,0, 0,0,1,0);
    rom[9] = mk(0,0,0,0, 0,0,0,0, 0,0,0,1);
    pulse_start();
    wait_idle();
    chk("R4 halt pc holds", W'(pc), W'(9));
    chk("R4 halt busy", W'(busy), '0);
    chk("R8 no error on legal writeback", W'(err), '0);
    hchk("R5 R6 add of dual read", 10, va + vb);
    hchk("R6 subtract 2p chained", 11, va + vb - TWOP);
    hchk("R6 zero operand", 12, va);
    hchk("R7 unit0 product", 13, va * vb);
    hchk("R7 unit1 product via result select", 14, va * vb);

    // prime host_rdata with a known slice before the busy run
    @(negedge clk); host_re = 1; host_addr = 8'd0; host_idx = 2'd1;
    @(negedge clk); host_re = 0;
    @(negedge clk);

    // program 2: early writeback while the host pokes
    for (int k = 0; k < 10; k++) rom[k] = mk(0,0,0,0,0,0,0,0,0,0,0,1);
    rom[0] = mk(1,0,1,1, 0,0,0,0, 0,0,0,0);
    rom[1] = mk(0,0,0,0, 0,0,0,0, 0,0,0,0);
    rom[2] = mk(0,0,0,0, 0,0,0,0, 1,2,0,0);
    rom[3] = mk(0,0,2,15, 0,0,0,0, 0,0,2,0);
    pulse_start();
    host_we = 1; host_addr = 8'd15; host_idx = 2'd0; host_wdata = 64'h0BAD_0BAD_0BAD_0BAD;
    host_re = 1;
    @(negedge clk); host_idx = 2'd3;
    @(negedge clk); host_we = 0; host_re = 0;
    wait_idle();
    repeat (2) @(negedge clk);
    chk("R9 host_rdata held while busy", W'(host_rdata), W'(va[127:64]));
    chk("R8 sticky err set", W'(err), W'(1));
    hchk("R8 R9 r15 unchanged", 15, vc);

    // program 3: halt only, start clears err
    rom[0] = mk(0,0,0,0,0,0,0,0,0,0,0,1);
    pulse_start();
    chk("R3 start sets busy", W'(busy), W'(1));
    chk("R3 start clears err", W'(err), '0);
    chk("R3 start pc zero", W'(pc), '0);
    @(negedge clk);
    chk("R4 halt clears busy", W'(busy), '0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule